// File: doc/BRIEF.md
# Configuration Image Loader with CRC-32 Verification

The block accepts a startup configuration image as a sequence of 32-bit words and decides whether the image may be trusted. An image begins with a fixed device identifier. Blocks follow in any order. Each block has a header word carrying an 8-bit block number, a length word, a CRC-32 word over those two words, the payload, and a CRC-32 word over the payload. A block whose length is zero closes the image. The word after its length word is a CRC-32 over every word of the image before it, starting with the identifier.

Payload words are presented on a table-write port in the same cycle they arrive, tagged with the block number and the word offset. They count as committed only when `tw_commit` pulses at the end of their block. A write flagged as a base-address write (`in_restart`) restarts loading from any state except the configured state. Words written without that flag continue at the next position, so an image can be spread over several bus transactions with idle cycles between them. `configured` rises only after the closing CRC matches. It then stays high and the loader ignores every write until reset.

States: `ST_IDLE` (wait for identifier), `ST_HDR` (block number word), `ST_LEN` (length word), `ST_HCRC` (header CRC), `ST_PAY` (payload), `ST_PCRC` (payload CRC), `ST_GCRC` (image CRC), `ST_DONE` (configured, locked), `ST_FAIL` (error, waiting for restart). Transitions:
- A restart word moves any state except `ST_DONE` to `ST_HDR` when it matches the identifier, and to `ST_IDLE` otherwise.
- Plain words advance the states as follows: `ST_HDR`→`ST_LEN`; `ST_LEN`→`ST_GCRC` when the length is zero, else `ST_HCRC`.
- `ST_HCRC`→`ST_PAY` when the CRC matches, else `ST_FAIL`.
- `ST_PAY`→`ST_PCRC` on the last payload word.
- `ST_PCRC`→`ST_HDR` when the CRC matches, else `ST_FAIL`.
- `ST_GCRC`→`ST_DONE` when the CRC matches, else `ST_FAIL`.
- Plain words leave `ST_IDLE`, `ST_DONE` and `ST_FAIL` unchanged.

Top module: `cfgld_loader`

## Requirements
- R1: After reset, `configured`, `error`, `busy`, `tw_valid` and `tw_commit` are 0 and `error_code` is 0.
- R2: Loading begins only on a restart write whose data equals parameter `DEV_ID`. A restart write with any other data leaves the loader idle (`busy`=0) with `error`=0.
- R3: The block number is bits [31:24] of the header word. The length is bits [LENW-1:0] of the next word. The third word must equal the CRC of those two words. On a mismatch the loader sets `error`=1 and `error_code`=1.
- R4: Each payload word raises `tw_valid` in the cycle it is written. At the same time `tw_data` carries the word, `tw_block` carries the block number, and `tw_offset` counts 0, 1, 2 and so on within the block.
- R5: The word after the payload must equal the CRC of the payload words. On a match, `tw_commit` pulses in that cycle with `tw_commit_block` set to the block number. On a mismatch, `tw_commit` stays 0 and the loader sets `error_code`=2.
- R6: A length of zero ends the image. The next word must equal the CRC of all image words from the identifier through that zero-length word. On a match `configured` becomes 1. On a mismatch the loader sets `error_code`=3.
- R7: The CRC is the Ethernet CRC-32: reflected polynomial EDB88320h, register preset to all ones and complemented at the end. Each word is fed low byte first, each byte bit 0 first, with all 32 bits included, unused bits as well. The CRC word is compared as a 32-bit value.
- R8: Blocks with any block numbers may follow one another in any order within one image.
- R9: Writes without `in_restart` continue the current image across idle cycles. A restart write in any state other than configured abandons the partial image without a commit and clears `error` and `error_code`.
- R10: Once `configured` is 1, every write, restart or not, is ignored until reset. No `tw_valid` or `tw_commit` is produced and the status does not change.
- R11: While `error`=1, `error_code` is nonzero and plain writes produce no table writes. The error holds until a restart or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Image word present |
| in_restart | input | 1 | Word written at the base address |
| in_data | input | 32 | Image word |
| tw_valid | output | 1 | Payload word on the table port |
| tw_block | output | 8 | Block number of the payload word |
| tw_offset | output | LENW | Word offset within the block |
| tw_data | output | 32 | Payload word |
| tw_commit | output | 1 | Block payload CRC passed |
| tw_commit_block | output | 8 | Block number being committed |
| busy | output | 1 | Image in progress |
| configured | output | 1 | Whole image verified |
| error | output | 1 | A CRC check failed |
| error_code | output | 2 | 0 none, 1 header, 2 payload, 3 image |

## Verification
The hardest case to reach from the ports is a restart that arrives partway through a block's payload. Some words have already appeared on the table port at that point, and the image CRC has absorbed them. The stimulus sends part of a block, restarts, and then sends a complete fresh image. It expects no commit for the abandoned block and a matching image CRC that covers only the second pass. Each CRC check is also made to fail on its own by flipping one bit in exactly one CRC word, so every error code is reached separately.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_HDR, ST_LEN, ST_HCRC, ST_PAY, ST_PCRC, ST_GCRC, ST_DONE, ST_FAIL
    } ld_state_t;

    typedef enum logic [1:0] {
        EC_NONE = 2'd0,
        EC_HDR  = 2'd1,
        EC_PAY  = 2'd2,
        EC_GLB  = 2'd3
    } ld_err_t;

    localparam logic [31:0] CRC_POLY_REV = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED     = 32'hFFFF_FFFF;

    // One word into a reflected CRC-32 register, bit 0 of byte 0 first.
    function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [31:0] d);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int i = 0; i < 32; i++) begin
            fb = c[0] ^ d[i];
            c  = {1'b0, c[31:1]} ^ (fb ? CRC_POLY_REV : 32'h0);
        end
        return c;
    endfunction

endpackage

// File: rtl/cfgld_crc_bank.sv
module cfgld_crc_bank
    import cfgld_pkg::*;
#(
    parameter int NUM_ACC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        din,
    input  logic [NUM_ACC-1:0] seed,
    input  logic [NUM_ACC-1:0] step,
    output logic [NUM_ACC-1:0] match
);

    logic [31:0] acc [NUM_ACC];

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc[g] <= CRC_SEED;
            end else if (seed[g]) begin
                acc[g] <= crc_step(CRC_SEED, din);
            end else if (step[g]) begin
                acc[g] <= crc_step(acc[g], din);
            end
        end
        assign match[g] = (din == ~acc[g]);
    end

endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
    import cfgld_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  logic      in_restart,
    input  logic      id_ok,
    input  logic      len_zero,
    input  logic      last_word,
    input  logic      hdr_ok,
    input  logic      pay_ok,
    input  logic      glb_ok,
    output ld_state_t state
);

    ld_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (in_valid && in_restart && state != ST_DONE) begin
            nxt = id_ok ? ST_HDR : ST_IDLE;
        end else if (in_valid && !in_restart) begin
            unique case (state)
                ST_IDLE, ST_DONE, ST_FAIL: nxt = state;
                ST_HDR:  nxt = ST_LEN;
                ST_LEN:  nxt = len_zero ? ST_GCRC : ST_HCRC;
                ST_HCRC: nxt = hdr_ok ? ST_PAY : ST_FAIL;
                ST_PAY:  nxt = last_word ? ST_PCRC : ST_PAY;
                ST_PCRC: nxt = pay_ok ? ST_HDR : ST_FAIL;
                ST_GCRC: nxt = glb_ok ? ST_DONE : ST_FAIL;
                default: nxt = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfgld_loader.sv
module cfgld_loader
    import cfgld_pkg::*;
#(
    parameter logic [31:0] DEV_ID = 32'hC0F1_6A01,
    parameter int          LENW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_restart,
    input  logic [31:0]     in_data,
    output logic            tw_valid,
    output logic [7:0]      tw_block,
    output logic [LENW-1:0] tw_offset,
    output logic [31:0]     tw_data,
    output logic            tw_commit,
    output logic [7:0]      tw_commit_block,
    output logic            busy,
    output logic            configured,
    output logic            error,
    output logic [1:0]      error_code
);

    localparam int ACC_HDR = 0;
    localparam int ACC_PAY = 1;
    localparam int ACC_GLB = 2;
    localparam int NUM_ACC = 3;

    ld_state_t         state;
    logic [7:0]        blk_id;
    logic [LENW-1:0]   blk_len;
    logic [LENW-1:0]   off;
    logic [NUM_ACC-1:0] seed, step, match;
    logic              accept, restart, id_ok, len_zero, last_word;

    assign accept    = in_valid && !in_restart;
    assign restart   = in_valid && in_restart && state != ST_DONE;
    assign id_ok     = (in_data == DEV_ID);
    assign len_zero  = (in_data[LENW-1:0] == '0);
    assign last_word = ((off + 1'b1) == blk_len);

    assign seed[ACC_HDR] = accept && state == ST_HDR;
    assign seed[ACC_PAY] = accept && state == ST_PAY && off == '0;
    assign seed[ACC_GLB] = restart && id_ok;
    assign step[ACC_HDR] = accept && state == ST_LEN;
    assign step[ACC_PAY] = accept && state == ST_PAY;
    assign step[ACC_GLB] = accept && (state inside {ST_HDR, ST_LEN, ST_HCRC, ST_PAY, ST_PCRC});

    cfgld_crc_bank #(.NUM_ACC(NUM_ACC)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (in_data),
        .seed  (seed),
        .step  (step),
        .match (match)
    );

    cfgld_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_restart (in_restart),
        .id_ok      (id_ok),
        .len_zero   (len_zero),
        .last_word  (last_word),
        .hdr_ok     (match[ACC_HDR]),
        .pay_ok     (match[ACC_PAY]),
        .glb_ok     (match[ACC_GLB]),
        .state      (state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_id     <= '0;
            blk_len    <= '0;
            off        <= '0;
            configured <= 1'b0;
            error      <= 1'b0;
            error_code <= EC_NONE;
        end else if (restart) begin
            error      <= 1'b0;
            error_code <= EC_NONE;
        end else if (accept) begin
            unique case (state)
                ST_HDR: blk_id  <= in_data[31:24];
                ST_LEN: blk_len <= in_data[LENW-1:0];
                ST_HCRC: begin
                    off <= '0;
                    if (!match[ACC_HDR]) begin
                        error      <= 1'b1;
                        error_code <= EC_HDR;
                    end
                end
                ST_PAY: off <= off + 1'b1;
                ST_PCRC: begin
                    if (!match[ACC_PAY]) begin
                        error      <= 1'b1;
                        error_code <= EC_PAY;
                    end
                end
                ST_GCRC: begin
                    if (match[ACC_GLB]) begin
                        configured <= 1'b1;
                    end else begin
                        error      <= 1'b1;
                        error_code <= EC_GLB;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        tw_valid        = accept && state == ST_PAY;
        tw_block        = blk_id;
        tw_offset       = off;
        tw_data         = in_data;
        tw_commit       = accept && state == ST_PCRC && match[ACC_PAY];
        tw_commit_block = blk_id;
        busy            = !(state inside {ST_IDLE, ST_DONE, ST_FAIL});
    end

endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_restart,
    input logic       tw_valid,
    input logic       tw_commit,
    input logic       busy,
    input logic       configured,
    input logic       error,
    input logic [1:0] error_code
);

    assert_locked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        configured |-> (!tw_valid && !tw_commit && !busy));

    assert_locked_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        configured |=> configured);

    assert_err_code_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (error_code != 2'd0));

    assert_err_code_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !error |-> (error_code == 2'd0));

    assert_err_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !tw_valid);

    assert_commit_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tw_commit |=> !error);

    assert_rise_on_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(configured) |-> $past(in_valid && !in_restart));

    assert_port_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tw_valid, tw_commit}));

endmodule

bind cfgld_loader cfgld_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_restart (in_restart),
    .tw_valid   (tw_valid),
    .tw_commit  (tw_commit),
    .busy       (busy),
    .configured (configured),
    .error      (error),
    .error_code (error_code)
);

// File: tb/cfgld_loader_tb.sv
module cfgld_loader_tb;

    localparam logic [31:0] DEV_ID = 32'hC0F1_6A01;
    localparam int          LENW   = 16;
    localparam logic [31:0] SEED   = 32'hFFFF_FFFF;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_restart = 1'b0;
    logic [31:0]     in_data = '0;
    logic            tw_valid, tw_commit, busy, configured, error;
    logic [7:0]      tw_block, tw_commit_block;
    logic [LENW-1:0] tw_offset;
    logic [31:0]     tw_data;
    logic [1:0]      error_code;

    int checks = 0;
    int errors = 0;

    logic            s_v, s_cm;
    logic [7:0]      s_blk, s_cmb;
    logic [LENW-1:0] s_off;
    logic [31:0]     s_dat;
    logic [31:0]     g;

    always #5 clk = ~clk;

    cfgld_loader #(.DEV_ID(DEV_ID), .LENW(LENW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_restart(in_restart),
        .in_data(in_data), .tw_valid(tw_valid), .tw_block(tw_block),
        .tw_offset(tw_offset), .tw_data(tw_data), .tw_commit(tw_commit),
        .tw_commit_block(tw_commit_block), .busy(busy), .configured(configured),
        .error(error), .error_code(error_code)
    );

    // mode: 0 good, 1 bad header CRC, 2 bad payload CRC, 3 bad image CRC
    localparam int NV = 6;
    localparam logic [15:0] VEC [NV] = '{
        {8'h11, 4'd1, 4'd0}, {8'h4E, 4'd5, 4'd0}, {8'h80, 4'd3, 4'd1},
        {8'h09, 4'd4, 4'd2}, {8'h05, 4'd2, 4'd3}, {8'h00, 4'd8, 4'd0}
    };

    function automatic logic [31:0] crc(input logic [31:0] c_in, input logic [31:0] d);
        logic [31:0] c;
        c = c_in;
        for (int i = 0; i < 32; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ 32'hEDB8_8320;
            else             c = c >> 1;
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic word(input logic rs, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_restart = rs; in_data = d;
        #1;
        s_v = tw_valid; s_blk = tw_block; s_off = tw_offset; s_dat = tw_data;
        s_cm = tw_commit; s_cmb = tw_commit_block;
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_restart = 1'b0;
    endtask

    task automatic wordg(input logic [31:0] d);
        word(1'b0, d);
        g = crc(g, d);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic start_image();
        word(1'b1, DEV_ID);
        g = crc(SEED, DEV_ID);
    endtask

    task automatic send_block(input logic [7:0] id, input logic [3:0] len, input int mode);
        logic [31:0] hw, lw, h, p, d;
        hw = {id, 16'h5AC3, 4'h0, len};
        lw = {16'h00A0, 12'h0, len};
        h  = crc(crc(SEED, hw), lw);
        wordg(hw);
        wordg(lw);
        wordg(~h ^ ((mode == 1) ? 32'h1 : 32'h0));
        if (mode == 1) begin
            chk("R3 header crc error code", {30'h0, error_code}, 32'd1);
            return;
        end
        p = SEED;
        for (int k = 0; k < int'(len); k++) begin
            d = {id, 8'(k), 16'hD00D};
            wordg(d);
            p = crc(p, d);
            chk("R4 tw_valid", {31'h0, s_v}, 32'd1);
            chk("R4 tw_block", {24'h0, s_blk}, {24'h0, id});
            chk("R4 tw_offset", {16'h0, s_off}, k);
            chk("R4 tw_data", s_dat, d);
        end
        wordg(~p ^ ((mode == 2) ? 32'h8000_0000 : 32'h0));
        chk("R5 commit", {31'h0, s_cm}, (mode == 2) ? 32'd0 : 32'd1);
        if (mode == 2) chk("R5 payload error code", {30'h0, error_code}, 32'd2);
        else           chk("R5 commit block", {24'h0, s_cmb}, {24'h0, id});
    endtask

    task automatic send_end(input logic bad);
        wordg({8'hE0, 24'h00_0000});
        wordg(32'hFFFF_0000);  // upper bits unused, length field zero
        word(1'b0, ~g ^ (bad ? 32'h10 : 32'h0));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1
        #1;
        chk("R1 configured", {31'h0, configured}, 0);
        chk("R1 error", {31'h0, error}, 0);
        chk("R1 error_code", {30'h0, error_code}, 0);
        chk("R1 busy", {31'h0, busy}, 0);
        chk("R1 tw_valid", {31'h0, tw_valid}, 0);

        // vector table: single-block images, then the closing block (R3 R5 R6 R7)
        for (int v = 0; v < NV; v++) begin
            int mode;
            mode = int'(VEC[v][3:0]);
            do_reset();
            start_image();
            send_block(VEC[v][15:8], VEC[v][7:4], mode);
            if (mode == 0 || mode == 3) begin
                send_end(mode == 3);
                chk("R6 configured", {31'h0, configured}, (mode == 0) ? 1 : 0);
                chk("R6 error_code", {30'h0, error_code}, (mode == 3) ? 3 : 0);
            end else begin
                word(1'b0, 32'h1234_5678);
                chk("R11 error held", {31'h0, error}, 1);
                chk("R11 no write in error", {31'h0, s_v}, 0);
            end
        end

        // R2: wrong identifier
        do_reset();
        word(1'b1, DEV_ID ^ 32'h1);
        chk("R2 busy after bad id", {31'h0, busy}, 0);
        chk("R2 no error on bad id", {31'h0, error}, 0);
        word(1'b0, 32'h0100_0000);
        chk("R2 plain word idle", {31'h0, busy}, 0);

        // R8 R9: two blocks, descending ids, gaps between words, one restart only
        do_reset();
        start_image();
        send_block(8'h13, 4'd2, 0);
        repeat (5) @(posedge clk);
        send_block(8'h02, 4'd1, 0);
        repeat (3) @(posedge clk);
        send_end(1'b0);
        chk("R8 R9 multi-block configured", {31'h0, configured}, 1);

        // R10: locked after configuration
        word(1'b1, DEV_ID);
        chk("R10 restart ignored busy", {31'h0, busy}, 0);
        chk("R10 still configured", {31'h0, configured}, 1);
        word(1'b0, 32'h0700_0000);
        chk("R10 no table write", {31'h0, s_v}, 0);
        chk("R10 no commit", {31'h0, s_cm}, 0);

        // R9: restart partway through a payload
        do_reset();
        start_image();
        begin
            logic [31:0] hw, lw;
            hw = {8'h21, 24'h00_0003};
            lw = 32'h0000_0003;
            wordg(hw);
            wordg(lw);
            wordg(~crc(crc(SEED, hw), lw));
            wordg(32'hAAAA_0000);
            chk("R4 partial payload emitted", {31'h0, s_v}, 1);
        end
        word(1'b1, DEV_ID);
        g = crc(SEED, DEV_ID);
        chk("R9 no commit on restart", {31'h0, s_cm}, 0);
        chk("R9 busy after restart", {31'h0, busy}, 1);
        send_block(8'h30, 4'd2, 0);
        send_end(1'b0);
        chk("R9 configured after restart", {31'h0, configured}, 1);

        // R9 R11: restart clears an error
        do_reset();
        start_image();
        send_block(8'h44, 4'd1, 1);
        chk("R11 error set", {31'h0, error}, 1);
        word(1'b1, DEV_ID);
        chk("R9 restart clears error", {31'h0, error}, 0);
        chk("R9 restart clears code", {30'h0, error_code}, 0);
        chk("R9 busy again", {31'h0, busy}, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule